// File: doc/BRIEF.md
# Accumulator with Extend Bit and Adder-Logic Network

This block holds the processor's working register together with a one-bit extend flag. Each clock cycle it applies at most one operation: it can combine the register with a 16-bit memory operand (bitwise AND, addition, or plain transfer), or take in an 8-bit character. It can also complement, increment or clear the register, or rotate it through the extend flag. Two more controls act on the extend flag alone, clearing or inverting it.

The control unit decodes instructions and drives one qualified strobe per operation. The block returns the sign bit, an all-zero indication and the extend flag to the skip logic. When no strobe is high, the block holds both the register and the flag.

Top module: `accumulator`

## Requirements
- R1: After reset (active-low `rst_n`), the accumulator is 0x0000 and the extend flag is 0.
- R2: `op_and` loads the bitwise AND of the accumulator and `dr_i`; the extend flag is unchanged.
- R3: `op_add` loads the low 16 bits of accumulator + `dr_i` and stores the carry out of bit 15 in the extend flag.
- R4: `op_ldr` loads `dr_i` into the accumulator; the extend flag is unchanged.
- R5: `op_inp` loads `inp_i` into accumulator bits 7:0; bits 15:8 and the extend flag keep their values.
- R6: `op_cma` loads the bitwise inverse of the accumulator; the extend flag is unchanged.
- R7: `op_cir` rotates the 17-bit ring {E, AC} right: E moves to bit 15, bits shift down by one, and bit 0 moves to E. Seventeen rotations restore the original state.
- R8: `op_cil` rotates the ring left: E moves to bit 0, bits shift up by one, and bit 15 moves to E.
- R9: `op_inc` adds one to the accumulator, wrapping 0xFFFF to 0x0000; the extend flag is unchanged.
- R10: `op_clr` sets the accumulator to zero and leaves the extend flag unchanged.
- R11: `op_cle` clears the extend flag and `op_cme` inverts it; neither touches the accumulator.
- R12: With no strobe asserted, the accumulator and the extend flag hold their values.
- R13: `sign_o` equals accumulator bit 15, `zero_o` is 1 exactly when all 16 bits are 0, and `e_o` equals the extend flag. All three reflect the registered state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_and | input | 1 | AND with operand |
| op_add | input | 1 | Add operand, carry to E |
| op_ldr | input | 1 | Transfer operand |
| op_inp | input | 1 | Transfer character to low byte |
| op_cma | input | 1 | Complement accumulator |
| op_cir | input | 1 | Rotate right through E |
| op_cil | input | 1 | Rotate left through E |
| op_inc | input | 1 | Increment accumulator |
| op_clr | input | 1 | Clear accumulator |
| op_cle | input | 1 | Clear E |
| op_cme | input | 1 | Complement E |
| dr_i | input | 16 | Memory operand |
| inp_i | input | 8 | Input character |
| ac_o | output | 16 | Accumulator value |
| e_o | output | 1 | Extend flag |
| sign_o | output | 1 | Accumulator bit 15 |
| zero_o | output | 1 | Accumulator equals zero |

## Verification
The bench builds the block with its default widths: a 16-bit register and an 8-bit character port. With these widths the edge cases take only a few operations to reach. These include the carry out of 0xFFFF + 0x0001, the wrap of an increment from 0xFFFF, and a full 17-step rotation back to the starting state. A behavioural model written in the bench is compared with every output after every clock.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef struct packed {
        logic and_op;
        logic add_op;
        logic ldr_op;
        logic inp_op;
        logic cma_op;
        logic cir_op;
        logic cil_op;
        logic inc_op;
        logic clr_op;
        logic cle_op;
        logic cme_op;
    } acc_ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IN_W   = 8
) (
    input  acc_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] ac_cur,
    input  logic              e_cur,
    input  logic [DATA_W-1:0] dr,
    input  logic [IN_W-1:0]   inp,
    output logic [DATA_W-1:0] ac_nxt,
    output logic              e_nxt
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] shr_w, shl_w;
    logic [DATA_W:0]   sum_w;
    logic [DATA_W-1:0] inc_w;
    logic [DATA_W-1:0] inp_w;

    // per-bit neighbour routing of the rotate network
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == MSB) begin : g_top
            assign shr_w[i] = e_cur;
        end else begin : g_shr
            assign shr_w[i] = ac_cur[i+1];
        end
        if (i == 0) begin : g_bot
            assign shl_w[i] = e_cur;
        end else begin : g_shl
            assign shl_w[i] = ac_cur[i-1];
        end
    end

    assign sum_w = {1'b0, ac_cur} + {1'b0, dr};
    assign inc_w = ac_cur + {{(DATA_W-1){1'b0}}, 1'b1};
    assign inp_w = {ac_cur[DATA_W-1:IN_W], inp};

    always_comb begin
        ac_nxt = ac_cur;
        e_nxt  = e_cur;
        unique case (1'b1)
            ctrl.and_op: ac_nxt = ac_cur & dr;
            ctrl.add_op: begin
                ac_nxt = sum_w[DATA_W-1:0];
                e_nxt  = sum_w[DATA_W];
            end
            ctrl.ldr_op: ac_nxt = dr;
            ctrl.inp_op: ac_nxt = inp_w;
            ctrl.cma_op: ac_nxt = ~ac_cur;
            ctrl.cir_op: begin
                ac_nxt = shr_w;
                e_nxt  = ac_cur[0];
            end
            ctrl.cil_op: begin
                ac_nxt = shl_w;
                e_nxt  = ac_cur[MSB];
            end
            ctrl.inc_op: ac_nxt = inc_w;
            ctrl.clr_op: ac_nxt = '0;
            ctrl.cle_op: e_nxt = 1'b0;
            ctrl.cme_op: e_nxt = ~e_cur;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] ac,
    input  logic              e,
    output logic              sign,
    output logic              zero,
    output logic              ext
);
    assign sign = ac[DATA_W-1];
    assign zero = ~|ac;
    assign ext  = e;
endmodule

// File: rtl/accumulator.sv
module accumulator
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_and,
    input  logic              op_add,
    input  logic              op_ldr,
    input  logic              op_inp,
    input  logic              op_cma,
    input  logic              op_cir,
    input  logic              op_cil,
    input  logic              op_inc,
    input  logic              op_clr,
    input  logic              op_cle,
    input  logic              op_cme,
    input  logic [DATA_W-1:0] dr_i,
    input  logic [IN_W-1:0]   inp_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              e_o,
    output logic              sign_o,
    output logic              zero_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ac;
        logic              e;
    } acc_state_t;

    acc_ctrl_t  ctrl;
    acc_state_t st_d, st_q;
    logic [DATA_W-1:0] ac_nxt;
    logic              e_nxt;

    assign ctrl = '{and_op: op_and, add_op: op_add, ldr_op: op_ldr,
                    inp_op: op_inp, cma_op: op_cma, cir_op: op_cir,
                    cil_op: op_cil, inc_op: op_inc, clr_op: op_clr,
                    cle_op: op_cle, cme_op: op_cme};

    acc_alu #(.DATA_W(DATA_W), .IN_W(IN_W)) u_alu (
        .ctrl  (ctrl),
        .ac_cur(st_q.ac),
        .e_cur (st_q.e),
        .dr    (dr_i),
        .inp   (inp_i),
        .ac_nxt(ac_nxt),
        .e_nxt (e_nxt)
    );

    always_comb begin
        st_d.ac = ac_nxt;
        st_d.e  = e_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    acc_flags #(.DATA_W(DATA_W)) u_flags (
        .ac  (st_q.ac),
        .e   (st_q.e),
        .sign(sign_o),
        .zero(zero_o),
        .ext (e_o)
    );

    assign ac_o = st_q.ac;

    // legality of the strobes: at most one per cycle
    a_ctl_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl));

    a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        op_add |=> ({e_o, ac_o} == {1'b0, $past(ac_o)} + {1'b0, $past(dr_i)}));

    a_r5_inp_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        op_inp |=> (ac_o[DATA_W-1:IN_W] == $past(ac_o[DATA_W-1:IN_W])) && $stable(e_o));

    a_r9_inc_keeps_e: assert property (@(posedge clk) disable iff (!rst_n)
        op_inc |=> $stable(e_o));

    a_r11_e_ops_keep_ac: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cle || op_cme) |=> $stable(ac_o));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == '0) |=> ($stable(ac_o) && $stable(e_o)));

    a_r7_cir_ring: assert property (@(posedge clk) disable iff (!rst_n)
        op_cir |=> (e_o == $past(ac_o[0])) && (ac_o[DATA_W-1] == $past(e_o)));
endmodule

// File: tb/tb_accumulator.sv
module tb_accumulator;
    localparam int DW = 16;
    localparam int IW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_and = 0, op_add = 0, op_ldr = 0, op_inp = 0, op_cma = 0, op_cir = 0;
    logic op_cil = 0, op_inc = 0, op_clr = 0, op_cle = 0, op_cme = 0;
    logic [DW-1:0] dr_i = '0;
    logic [IW-1:0] inp_i = '0;
    logic [DW-1:0] ac_o;
    logic e_o, sign_o, zero_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] m_ac = '0;
    logic          m_e  = 1'b0;

    always #5 clk = ~clk;

    accumulator #(.DATA_W(DW), .IN_W(IW)) dut (
        .clk(clk), .rst_n(rst_n),
        .op_and(op_and), .op_add(op_add), .op_ldr(op_ldr), .op_inp(op_inp),
        .op_cma(op_cma), .op_cir(op_cir), .op_cil(op_cil), .op_inc(op_inc),
        .op_clr(op_clr), .op_cle(op_cle), .op_cme(op_cme),
        .dr_i(dr_i), .inp_i(inp_i),
        .ac_o(ac_o), .e_o(e_o), .sign_o(sign_o), .zero_o(zero_o)
    );

    task automatic check(input string req);
        logic [DW+2:0] act, exp;
        act = {ac_o, e_o, sign_o, zero_o};
        exp = {m_ac, m_e, m_ac[DW-1], (m_ac == 0)};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {ac,e,sign,zero} actual %h expected %h", req, act, exp);
        end
    endtask

    // op codes local to the bench: 0 idle,1 and,2 add,3 ldr,4 inp,5 cma,
    // 6 cir,7 cil,8 inc,9 clr,10 cle,11 cme
    task automatic step(input int op, input logic [DW-1:0] d, input logic [IW-1:0] c,
                        input string req);
        int s;
        @(negedge clk);
        dr_i = d; inp_i = c;
        op_and = (op == 1); op_add = (op == 2); op_ldr = (op == 3); op_inp = (op == 4);
        op_cma = (op == 5); op_cir = (op == 6); op_cil = (op == 7); op_inc = (op == 8);
        op_clr = (op == 9); op_cle = (op == 10); op_cme = (op == 11);
        case (op)
            1: m_ac = m_ac & d;
            2: begin s = int'(m_ac) + int'(d); m_ac = s[15:0]; m_e = s[16]; end
            3: m_ac = d;
            4: m_ac[7:0] = c;
            5: m_ac = ~m_ac;
            6: {m_ac, m_e} = {m_e, m_ac};
            7: {m_e, m_ac} = {m_ac, m_e};
            8: m_ac = m_ac + 16'd1;
            9: m_ac = '0;
            10: m_e = 1'b0;
            11: m_e = ~m_e;
            default: ;
        endcase
        @(negedge clk);
        {op_and, op_add, op_ldr, op_inp, op_cma, op_cir, op_cil, op_inc, op_clr, op_cle, op_cme} = '0;
        check(req);
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        step(0, 16'hAAAA, 8'h55, "R12 idle after reset");
        step(3, 16'h1234, 8'h00, "R4 load");
        step(1, 16'h0F0F, 8'h00, "R2 and");
        step(3, 16'hFFFF, 8'h00, "R4 load ones R13 sign");
        step(2, 16'h0001, 8'h00, "R3 add carry R13 zero");
        step(2, 16'h7000, 8'h00, "R3 add no carry");
        step(11, 16'h0000, 8'h00, "R11 cme sets");
        step(3, 16'hBEEF, 8'h00, "R4 load keeps e");
        step(4, 16'h0000, 8'hC3, "R5 inp low byte");
        step(5, 16'h0000, 8'h00, "R6 complement");
        step(6, 16'h0000, 8'h00, "R7 cir");
        for (int k = 0; k < 16; k++) step(6, 16'h0000, 8'h00, "R7 cir ring");
        step(7, 16'h0000, 8'h00, "R8 cil");
        step(7, 16'h0000, 8'h00, "R8 cil again");
        step(3, 16'hFFFF, 8'h00, "R4 load max");
        step(8, 16'h0000, 8'h00, "R9 inc wrap");
        step(8, 16'h0000, 8'h00, "R9 inc");
        step(10, 16'h0000, 8'h00, "R11 cle");
        step(11, 16'h0000, 8'h00, "R11 cme");
        step(9, 16'h0000, 8'h00, "R10 clear keeps e");
        step(3, 16'h8001, 8'h00, "R4 load");
        step(0, 16'h1111, 8'hFF, "R12 idle hold");
        step(7, 16'h0000, 8'h00, "R8 cil msb to e");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule